// File: doc/BRIEF.md
# DRAM bank command sequencer

This block sits between a request source and the command pins of one DRAM rank. It takes one read or write at a time, each naming a bank, a row and a column. It turns that request into a timed series of activate, precharge, read, write and refresh commands. It keeps an open-row record for every bank, and that record decides how each access is served. An access to the row already open in its bank gets only a column command. An access to a bank with no open row gets an activate and then the column command. An access to a bank holding some other row gets a precharge, an activate and then the column command. After a column access the row stays open, so a later access to the same row is a hit.

All timing values are parameters counted in controller clocks: precharge-to-activate, activate-to-column, column-to-data, refresh recovery and the refresh interval. A refresh timer raises a pending flag on a fixed schedule. The next time the sequencer is idle, the refresh is served before any waiting request: each open bank is closed in turn, and then the refresh command is sent. When an access completes, a one-cycle done pulse reports how the access was classified, so the latency of each path can be checked from outside.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, req_ready is high and no command is issued. Every bank counts as closed, so the first access to any bank takes the closed path. The refresh timer starts from zero, so the first refresh becomes pending exactly T_REFI cycles after reset is released.
- R2: For a hit (the requested row is open in that bank), the column command is the only command. It is issued in the cycle after acceptance, and done pulses T_CL cycles later with done_class = 0.
- R3: For a closed bank, an activate (cmd_op = 1) is issued in the cycle after acceptance. The column command follows T_RCD cycles later, and done follows T_CL cycles after that with done_class = 1.
- R4: For a conflict (a different row is open), a precharge (cmd_op = 2) is issued in the cycle after acceptance. The activate follows T_RP cycles later, the column command T_RCD cycles after the activate, and done T_CL cycles after the column command with done_class = 2.
- R5: The row stays open after a column access. A later request to the same bank and row is served as a hit.
- R6: The column command is a read (cmd_op = 3) when req_write is low and a write (cmd_op = 4) when it is high. It carries the bank and the column. An activate carries the bank and the row. A precharge carries the bank.
- R7: A refresh becomes pending every T_REFI cycles. While a refresh is pending, req_ready is low. Once the sequencer is idle, the pending refresh is served before any waiting request. The refresh command (cmd_op = 5) is followed by T_RFC cycles before the next request can be accepted.
- R8: To serve a refresh, each open bank is precharged, one per cycle, in ascending bank order. The refresh command follows T_RP cycles after the last of these precharges. If no bank is open, the refresh command comes in the first cycle after idle. After a refresh every bank is closed, so the next access to any bank takes the closed path.
- R9: A request is accepted only at a clock edge where req_valid and req_ready are both high. req_ready is high only while the sequencer is idle. At most one command is issued per cycle, and cmd_valid is high exactly when cmd_op is nonzero. done is a single-cycle pulse, and a new request can be accepted in the cycle after done.
- R10: Banks are independent, and an activate or precharge in one bank leaves the open row of every other bank unchanged. The bank index is flat, with the group in its upper bits: index = group * GROUP_BANKS + member.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Sequencer is idle and will accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Flat bank index (group in upper bits) |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | 0 none, 1 activate, 2 precharge, 3 read, 4 write, 5 refresh |
| cmd_bank | output | BANK_W | Bank of the command (zero for refresh) |
| cmd_row | output | ROW_W | Row of an activate, zero otherwise |
| cmd_col | output | COL_W | Column of a read or write, zero otherwise |
| done | output | 1 | One-cycle pulse when the access data latency has elapsed |
| done_class | output | 2 | With done: 0 hit, 1 closed bank, 2 conflict |

## Verification
The spacing assertions rely on two assumptions: every timing parameter is at least two clocks, and T_REFI is long enough that a refresh tick cannot land while an earlier refresh sequence is still running. Elaboration checks enforce the first. The bench sets the refresh interval to 200 cycles, which leaves ample margin over the longest refresh walk plus recovery. Request fields are latched at acceptance, so the bench may hold or change them freely while req_ready is low. The stimulus holds the next request valid during busy and refresh periods, which exercises the hold-off without violating any assumption.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_ACT = 3'd1,
      OP_PRE = 3'd2,
      OP_RD  = 3'd3,
      OP_WR  = 3'd4,
      OP_REF = 3'd5
   } dbs_op_e;

   typedef enum logic [1:0] {
      CLS_HIT      = 2'd0,
      CLS_CLOSED   = 2'd1,
      CLS_CONFLICT = 2'd2
   } dbs_cls_e;

   typedef enum logic [3:0] {
      S_IDLE, S_PRE, S_WPRE, S_ACT, S_WACT, S_COL, S_WCL, S_DONE,
      S_RPRE, S_RWP, S_REF, S_RWAIT
   } dbs_state_e;

endpackage

// File: rtl/dbs_bank_table.sv
module dbs_bank_table import dbs_pkg::*; #(
   parameter int NUM_BANKS = 32,
   parameter int ROW_W     = 14,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] look_bank,
   input  logic [ROW_W-1:0]  look_row,
   output dbs_cls_e          look_cls,
   input  logic              set_en,
   input  logic [BANK_W-1:0] set_bank,
   input  logic [ROW_W-1:0]  set_row,
   input  logic              clr_en,
   input  logic [BANK_W-1:0] clr_bank,
   output logic              any_open,
   output logic              last_open,
   output logic [BANK_W-1:0] low_open
);

   logic [NUM_BANKS-1:0] open_vec;
   logic [ROW_W-1:0]     row_arr [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             open_r;
      logic [ROW_W-1:0] row_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_r <= 1'b0;
            row_r  <= '0;
         end else if (set_en && set_bank == BANK_W'(b)) begin
            open_r <= 1'b1;
            row_r  <= set_row;
         end else if (clr_en && clr_bank == BANK_W'(b)) begin
            open_r <= 1'b0;
         end
      end
      assign open_vec[b] = open_r;
      assign row_arr[b]  = row_r;
   end

   always_comb begin
      if (!open_vec[look_bank])                look_cls = CLS_CLOSED;
      else if (row_arr[look_bank] == look_row) look_cls = CLS_HIT;
      else                                     look_cls = CLS_CONFLICT;
   end

   always_comb begin
      low_open = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (open_vec[i]) low_open = BANK_W'(i);
      end
   end

   assign any_open  = |open_vec;
   assign last_open = $onehot(open_vec);

   // R4 / R3: an activate only ever targets a bank with no open row
   a_r4_act_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !open_vec[set_bank]);

   // R8: a precharge only ever targets a bank that holds an open row
   a_r8_pre_only_open: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> open_vec[clr_bank]);

   // R10: an activate of one bank never disturbs the open state of another
   a_r10_set_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en) |=> ($countones(open_vec) == $countones($past(open_vec)) + 1));

endmodule

// File: rtl/dbs_refresh_timer.sv
module dbs_refresh_timer #(
   parameter int T_REFI = 6240,
   localparam int CW    = $clog2(T_REFI)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_issue,
   output logic ref_pend
);

   logic [CW-1:0] cnt;
   logic          tick;

   assign tick = (cnt == CW'(T_REFI - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         ref_pend <= 1'b0;
      end else begin
         cnt <= tick ? '0 : cnt + 1'b1;
         if (tick)           ref_pend <= 1'b1;
         else if (ref_issue) ref_pend <= 1'b0;
      end
   end

   // R7: a pending refresh is held until the refresh command goes out
   a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pend && !ref_issue) |=> ref_pend);

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq import dbs_pkg::*; #(
   parameter int NUM_GROUPS  = 4,
   parameter int GROUP_BANKS = 8,
   parameter int ROW_W       = 14,
   parameter int COL_W       = 10,
   parameter int T_RP        = 4,
   parameter int T_RCD       = 4,
   parameter int T_CL        = 5,
   parameter int T_RFC       = 20,
   parameter int T_REFI      = 6240,
   localparam int NUM_BANKS  = NUM_GROUPS * GROUP_BANKS,
   localparam int BANK_W     = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              cmd_valid,
   output logic [2:0]        cmd_op,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic              done,
   output logic [1:0]        done_class
);

   localparam int T_MAX01 = (T_RP > T_RCD) ? T_RP : T_RCD;
   localparam int T_MAX23 = (T_CL > T_RFC) ? T_CL : T_RFC;
   localparam int T_MAX   = (T_MAX01 > T_MAX23) ? T_MAX01 : T_MAX23;
   localparam int CNT_W   = $clog2(T_MAX + 1);
   localparam int SEQ_MAX = NUM_BANKS + T_RP + T_RFC + T_RP + T_RCD + T_CL + 2;

   if (T_RP < 2 || T_RCD < 2 || T_CL < 2 || T_RFC < 2) begin : g_bad_timing
      $error("dram_bank_seq: every timing parameter must be at least 2");
   end
   if ((NUM_GROUPS & (NUM_GROUPS - 1)) != 0 || (GROUP_BANKS & (GROUP_BANKS - 1)) != 0
       || NUM_BANKS < 2) begin : g_bad_banks
      $error("dram_bank_seq: group and bank counts must be powers of two");
   end
   if (T_REFI <= SEQ_MAX) begin : g_bad_refi
      $error("dram_bank_seq: refresh interval too short for one full sequence");
   end

   dbs_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic              rq_write;
   logic [BANK_W-1:0] rq_bank;
   logic [ROW_W-1:0]  rq_row;
   logic [COL_W-1:0]  rq_col;
   dbs_cls_e          rq_cls;

   dbs_op_e           op;
   dbs_cls_e          look_cls;
   logic              set_en, clr_en, any_open, last_open, ref_pend, ref_issue;
   logic [BANK_W-1:0] clr_bank, low_open;

   dbs_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .look_bank(req_bank), .look_row(req_row), .look_cls(look_cls),
      .set_en(set_en), .set_bank(rq_bank), .set_row(rq_row),
      .clr_en(clr_en), .clr_bank(clr_bank),
      .any_open(any_open), .last_open(last_open), .low_open(low_open)
   );

   dbs_refresh_timer #(.T_REFI(T_REFI)) u_timer (
      .clk(clk), .rst_n(rst_n), .ref_issue(ref_issue), .ref_pend(ref_pend)
   );

   assign req_ready = (st == S_IDLE) && !ref_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         rq_write <= 1'b0;
         rq_bank  <= '0;
         rq_row   <= '0;
         rq_col   <= '0;
         rq_cls   <= CLS_HIT;
      end else begin
         case (st)
            S_IDLE: begin
               if (ref_pend) begin
                  st <= any_open ? S_RPRE : S_REF;
               end else if (req_valid) begin
                  rq_write <= req_write;
                  rq_bank  <= req_bank;
                  rq_row   <= req_row;
                  rq_col   <= req_col;
                  rq_cls   <= look_cls;
                  case (look_cls)
                     CLS_HIT:    st <= S_COL;
                     CLS_CLOSED: st <= S_ACT;
                     default:    st <= S_PRE;
                  endcase
               end
            end
            S_PRE:  begin st <= S_WPRE; cnt <= CNT_W'(T_RP - 2);  end
            S_WPRE: if (cnt == '0) st <= S_ACT; else cnt <= cnt - 1'b1;
            S_ACT:  begin st <= S_WACT; cnt <= CNT_W'(T_RCD - 2); end
            S_WACT: if (cnt == '0) st <= S_COL; else cnt <= cnt - 1'b1;
            S_COL:  begin st <= S_WCL;  cnt <= CNT_W'(T_CL - 2);  end
            S_WCL:  if (cnt == '0) st <= S_DONE; else cnt <= cnt - 1'b1;
            S_DONE: st <= S_IDLE;
            S_RPRE: if (last_open) begin st <= S_RWP; cnt <= CNT_W'(T_RP - 2); end
            S_RWP:  if (cnt == '0) st <= S_REF; else cnt <= cnt - 1'b1;
            S_REF:  begin st <= S_RWAIT; cnt <= CNT_W'(T_RFC - 2); end
            S_RWAIT: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      op        = OP_NOP;
      cmd_bank  = '0;
      cmd_row   = '0;
      cmd_col   = '0;
      set_en    = 1'b0;
      clr_en    = 1'b0;
      clr_bank  = rq_bank;
      ref_issue = 1'b0;
      case (st)
         S_PRE:  begin op = OP_PRE; cmd_bank = rq_bank; clr_en = 1'b1; end
         S_ACT:  begin op = OP_ACT; cmd_bank = rq_bank; cmd_row = rq_row; set_en = 1'b1; end
         S_COL:  begin op = rq_write ? OP_WR : OP_RD; cmd_bank = rq_bank; cmd_col = rq_col; end
         S_RPRE: begin op = OP_PRE; cmd_bank = low_open; clr_en = 1'b1; clr_bank = low_open; end
         S_REF:  begin op = OP_REF; ref_issue = 1'b1; end
         default: ;
      endcase
   end

   assign cmd_op     = op;
   assign cmd_valid  = (op != OP_NOP);
   assign done       = (st == S_DONE);
   assign done_class = done ? rq_cls : 2'd0;

   // Spacing counters that watch the command stream for the checks below
   logic [CNT_W-1:0] since_pre, since_act, since_col;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_pre <= '1;
         since_act <= '1;
         since_col <= '1;
      end else begin
         since_pre <= (cmd_op == OP_PRE) ? CNT_W'(1) : (since_pre == '1 ? since_pre : since_pre + 1'b1);
         since_act <= (cmd_op == OP_ACT) ? CNT_W'(1) : (since_act == '1 ? since_act : since_act + 1'b1);
         since_col <= (cmd_op == OP_RD || cmd_op == OP_WR) ? CNT_W'(1)
                      : (since_col == '1 ? since_col : since_col + 1'b1);
      end
   end

   a_r4_act_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_ACT) |-> (since_pre >= CNT_W'(T_RP)));

   a_r8_ref_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_REF) |-> (since_pre >= CNT_W'(T_RP)));

   a_r3_col_after_act: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_RD || cmd_op == OP_WR) |-> (since_act >= CNT_W'(T_RCD)));

   a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_col == CNT_W'(T_CL)));

   a_r8_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_REF) |-> !any_open);

   a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!cmd_valid && !done));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/dram_bank_seq_test.sv
module dram_bank_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int NG = 4, GB = 8, NB = 32, BW = 5, RW = 14, CW = 10;
   localparam int TRP = 4, TRCD = 4, TCL = 5, TRFC = 20, TREFI = 200;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [BW-1:0] req_bank = '0;
   logic [RW-1:0] req_row = '0;
   logic [CW-1:0] req_col = '0;
   logic req_ready, cmd_valid, done;
   logic [2:0] cmd_op;
   logic [BW-1:0] cmd_bank;
   logic [RW-1:0] cmd_row;
   logic [CW-1:0] cmd_col;
   logic [1:0] done_class;

   dram_bank_seq #(.NUM_GROUPS(NG), .GROUP_BANKS(GB), .ROW_W(RW), .COL_W(CW),
      .T_RP(TRP), .T_RCD(TRCD), .T_CL(TCL), .T_RFC(TRFC), .T_REFI(TREFI)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
      .cmd_col(cmd_col), .done(done), .done_class(done_class)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct packed {
      logic          wr;
      logic [BW-1:0] bank;
      logic [RW-1:0] row;
      logic [CW-1:0] col;
   } req_t;

   req_t q[$];
   int tests = 0, fails = 0;

   // behavioural reference state
   bit    m_open[NB];
   int    m_row[NB];
   bit    m_touched[NB];
   bit    m_refclr[NB];
   int    m_free = 0;
   bit    m_pend = 0;
   int    last_bank = -1;
   int    exp_op[int], exp_bank[int], exp_row[int], exp_col[int], exp_cls[int];
   string exp_tag[int], done_tag[int];
   int    n_hit = 0, n_conf = 0, n_closed = 0, n_ref = 0, n_refpre = 0, n_xhit = 0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
      end
   endtask

   function automatic req_t mk(input bit wr, input int b, input int r, input int c);
      req_t x;
      x.wr = wr; x.bank = BW'(b); x.row = RW'(r); x.col = CW'(c);
      return x;
   endfunction

   task automatic sched_refresh(input int c);
      int t = c + 1;
      int k = 0;
      for (int b = 0; b < NB; b++) begin
         if (m_open[b]) begin
            exp_op[t] = 2; exp_bank[t] = b; exp_tag[t] = "R8";
            t++; k++;
            m_open[b] = 0; m_refclr[b] = 1;
         end
      end
      if (k > 0) t = t - 1 + TRP;
      exp_op[t] = 5; exp_bank[t] = 0; exp_tag[t] = (n_ref == 0) ? "R1" : "R7";
      m_free = t + TRFC;
      m_pend = 0;
      n_ref++;
      n_refpre += k;
   endtask

   task automatic sched_access(input int c, input req_t r);
      int b = int'(r.bank);
      int cls, t;
      string tg;
      if (!m_open[b]) begin
         cls = 1; n_closed++;
         tg = !m_touched[b] ? "R1" : (m_refclr[b] ? "R8" : "R3");
      end else if (m_row[b] == int'(r.row)) begin
         cls = 0; n_hit++;
         if (last_bank >= 0 && last_bank != b) begin tg = "R10"; n_xhit++; end
         else tg = "R2";
      end else begin
         cls = 2; n_conf++; tg = "R4";
      end
      t = c + 1;
      if (cls == 2) begin
         exp_op[t] = 2; exp_bank[t] = b; exp_tag[t] = "R4";
         t += TRP;
      end
      if (cls != 0) begin
         exp_op[t] = 1; exp_bank[t] = b; exp_row[t] = int'(r.row); exp_tag[t] = tg;
         t += TRCD;
      end
      exp_op[t] = r.wr ? 4 : 3; exp_bank[t] = b; exp_col[t] = int'(r.col);
      exp_tag[t] = r.wr ? "R6" : tg;
      t += TCL;
      exp_cls[t] = cls; done_tag[t] = tg;
      m_free = t + 1;
      m_open[b] = 1; m_row[b] = int'(r.row); m_touched[b] = 1; m_refclr[b] = 0;
      last_bank = b;
   endtask

   task automatic drive(input req_t r);
      req_valid = 1'b1; req_write = r.wr; req_bank = r.bank; req_row = r.row; req_col = r.col;
   endtask

   task automatic step(input int c);
      bit    e_ready, ed;
      int    eop;
      string tg;
      req_t  r;
      if (c > 0 && c % TREFI == 0) m_pend = 1;
      e_ready = (c >= m_free) && !m_pend;
      chk(req_ready === e_ready, c == 0 ? "R1" : (m_pend ? "R7" : "R9"), "req_ready",
          int'(req_ready), int'(e_ready));
      eop = exp_op.exists(c) ? exp_op[c] : 0;
      tg  = exp_op.exists(c) ? exp_tag[c] : (c == 0 ? "R1" : "R9");
      chk(int'(cmd_op) == eop, tg, "cmd_op", int'(cmd_op), eop);
      chk(cmd_valid === (eop != 0), tg, "cmd_valid", int'(cmd_valid), int'(eop != 0));
      if (eop != 0 && eop != 5) chk(int'(cmd_bank) == exp_bank[c], tg, "cmd_bank", int'(cmd_bank), exp_bank[c]);
      if (eop == 1) chk(int'(cmd_row) == exp_row[c], "R6", "cmd_row", int'(cmd_row), exp_row[c]);
      if (eop == 3 || eop == 4) chk(int'(cmd_col) == exp_col[c], "R6", "cmd_col", int'(cmd_col), exp_col[c]);
      ed = exp_cls.exists(c);
      chk(done === ed, ed ? done_tag[c] : "R9", "done", int'(done), int'(ed));
      if (ed) chk(int'(done_class) == exp_cls[c], done_tag[c], "done_class", int'(done_class), exp_cls[c]);
      // decide what happens at the next edge
      if (c >= m_free && m_pend) sched_refresh(c);
      if (c >= m_free && !m_pend && q.size() > 0) begin
         r = q.pop_front();
         drive(r);
         sched_access(c, r);
      end else if (q.size() > 0) begin
         drive(q[0]);
      end else begin
         req_valid = 1'b0;
      end
   endtask

   initial begin
      logic [15:0] lfsr;
      int c;
      bit fin;
      // directed opening sequence
      q.push_back(mk(0, 0, 5, 1));          // closed after reset (R1)
      q.push_back(mk(1, 0, 5, 2));          // hit, write (R2, R5, R6)
      q.push_back(mk(0, 0, 9, 3));          // conflict (R4)
      q.push_back(mk(0, 8, 9, 4));          // closed in group 1 (R3)
      q.push_back(mk(0, 0, 9, 5));          // hit after other bank (R10)
      q.push_back(mk(1, 31, 16383, 1023));  // last bank, top row and column
      q.push_back(mk(0, 31, 0, 0));         // conflict at bottom row
      lfsr = 16'hACE1;
      for (int i = 0; i < 250; i++) begin
         int b, r;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[1:0])
            2'd0: b = 0;
            2'd1: b = 1;
            2'd2: b = 8;
            default: b = 31;
         endcase
         case (lfsr[3:2])
            2'd0: r = 0;
            2'd1: r = 3;
            2'd2: r = 16383;
            default: r = 3;
         endcase
         q.push_back(mk(lfsr[15], b, r, int'(lfsr[13:4])));
      end

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      c = 0;
      fin = 0;
      while (!fin) begin
         step(c);
         if (q.size() == 0 && c >= m_free && n_ref >= 3) begin
            fin = 1;
         end else if (c >= WATCHDOG) begin
            tests++; fails++;
            $display("FAIL R9 watchdog: got %0d cycles expected fewer than %0d", c, WATCHDOG);
            fin = 1;
         end else begin
            @(negedge clk);
            c++;
         end
      end

      chk(n_hit > 0, "R5", "hits seen", n_hit, 1);
      chk(n_conf > 0, "R4", "conflicts seen", n_conf, 1);
      chk(n_closed > 0, "R3", "closed accesses seen", n_closed, 1);
      chk(n_xhit > 0, "R10", "hits across bank switches", n_xhit, 1);
      chk(n_ref >= 3, "R7", "refreshes seen", n_ref, 3);
      chk(n_refpre > 0, "R8", "refresh precharges seen", n_refpre, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule